// File: doc/BRIEF.md
# Road-Based Hit Filter Sequencer

This block runs one event through a hit filter that has external comparators, an external hit formatter and two external FIFOs. After an event start it loads track roads: each road-write strobe places one road into the next free comparator, and a road counter keeps the running total. Loading ends on a last-road flag. That flag may arrive together with the final road, or on its own, which means the event has no further roads. The counter value is exported to the formatter as the upper limit for its hit search.

Once loading has ended, the sequencer pulls centroids from the centroid FIFO one at a time and routes each one by the two-bit type code in the top bits of the word. A z-axis centroid (2'b10) has its type bits stripped and is written into the z-axis FIFO. An axial centroid (2'b11) is presented to the comparators. The block then reads the comparator outputs, reads the masked hit register (which also triggers the formatter) and waits for the formatter's done flag. Any other code is dropped and counted. When the centroid FIFO is empty, the block returns to idle if the event has ended. Otherwise it parks in a data-wait state until more centroids arrive.

Top module: `road_hit_ctrl`

## Requirements
- R1: After reset, hits_busy, cfifo_rd, cmp_we, cmp_rd, mask_rd and zfifo_wr are 0 and road_cnt and drop_cnt are 0.
- R2: An event start taken while idle clears road_cnt and drop_cnt to 0.
- R3: During loading, each assertion of road_wr produces exactly one cmp_we pulse with cmp_sel equal to the road count before the write, and road_cnt rises by one. A road_wr held high for several cycles loads only once, and another road is accepted only after road_wr has been low.
- R4: road_cnt saturates at MAX_ROADS. Further road writes produce no cmp_we pulse and leave road_cnt unchanged.
- R5: A road_last seen together with road_wr ends loading after that road is loaded. A road_last seen alone ends loading with the count unchanged, which is 0 when the event had no roads.
- R6: No centroid is read (cfifo_rd stays 0) while roads are still being loaded, even when the centroid FIFO is not empty.
- R7: After loading, a non-empty centroid FIFO produces a one-cycle cfifo_rd pulse. The FIFO returns the word on the following cycle. hits_busy is 1 from the first read until the block returns to idle.
- R8: A centroid whose bits [DW-1:DW-2] equal 2'b10 causes one zfifo_wr pulse with cent_word equal to bits [DW-3:0] of the centroid, and no cmp_rd.
- R9: A centroid whose type bits equal 2'b11 causes a one-cycle cmp_rd pulse with cent_word equal to bits [DW-3:0], followed in the next cycle by a one-cycle mask_rd pulse, and no zfifo_wr.
- R10: After mask_rd, no further centroid is read until fmt_done is seen high.
- R11: A centroid whose type bits are 2'b00 or 2'b01 produces no zfifo_wr, cmp_rd or mask_rd, and drop_cnt rises by one.
- R12: With the centroid FIFO empty, the block returns to idle (hits_busy falls) if evt_end is high. If evt_end is low it waits, and it resumes reading when the FIFO becomes non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_start | input | 1 | Starts an event when idle |
| evt_end | input | 1 | Event has ended (no more centroids will arrive) |
| road_wr | input | 1 | Road write strobe from the road source |
| road_last | input | 1 | Last road of the event |
| cmp_we | output | 1 | Load the current road into comparator cmp_sel |
| cmp_sel | output | SELW | Comparator index for the road being loaded |
| road_cnt | output | CW | Number of roads loaded (hit search limit) |
| cfifo_empty | input | 1 | Centroid FIFO empty |
| cfifo_rd | output | 1 | Centroid FIFO read strobe |
| cfifo_data | input | DW | Centroid FIFO output word, valid the cycle after cfifo_rd |
| cent_word | output | DW-2 | Centroid payload for the comparators and the z-axis FIFO |
| cmp_rd | output | 1 | Read comparator outputs |
| mask_rd | output | 1 | Read masked hit register and start the formatter |
| fmt_done | input | 1 | Formatter finished with the current centroid |
| zfifo_wr | output | 1 | Write cent_word into the z-axis FIFO |
| hits_busy | output | 1 | Centroid processing in progress for this event |
| drop_cnt | output | DROPW | Count of centroids dropped for an unknown type |

## Verification
The hardest state to reach is the data-wait park. The event must still be open, the roads must already be loaded and the FIFO must have just run dry after centroids were processed. The stimulus gets there by pushing centroids into the bench FIFO while roads are still loading, which also shows that no read happens early. It then closes loading, lets the queue drain with evt_end low, and feeds a late centroid of an unknown type to show that the block resumes and drops it. A second hard spot is the formatter wait. The bench disables its automatic done response, queues a z-axis centroid behind an axial one, and confirms that the z-axis write is held back until a manual done pulse.

// File: rtl/rhc_pkg.sv
package rhc_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_FIRST,
    S_LOAD,
    S_RELEASE,
    S_NEXT,
    S_READ,
    S_DECIDE,
    S_ZWRITE,
    S_CMP,
    S_MASK,
    S_WAITDONE,
    S_DWAIT
  } rhc_state_t;

  localparam logic [1:0] TYP_Z  = 2'b10;
  localparam logic [1:0] TYP_AX = 2'b11;
endpackage

// File: rtl/rhc_sat_counter.sv
module rhc_sat_counter #(
  parameter int MAX = 12,
  parameter int W   = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         full
);
  localparam logic [W-1:0] LIMIT = W'(MAX);

  assign full = (cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc && !full)
      cnt <= cnt + 1'b1;
  end

  // R4: never beyond the limit
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);

  // R3: any change without a clear is a single step up
  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr) && !$past(rst) && cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/rhc_cent_latch.sv
module rhc_cent_latch #(
  parameter int DW = 16,
  localparam int PW = DW - 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [DW-1:0] din,
  output logic [PW-1:0] payload
);
  always_ff @(posedge clk) begin
    if (rst)
      payload <= '0;
    else if (cap)
      payload <= din[PW-1:0];
  end
endmodule

// File: rtl/rhc_fsm.sv
module rhc_fsm
  import rhc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       evt_start,
  input  logic       evt_end,
  input  logic       road_wr,
  input  logic       road_last,
  input  logic       roads_full,
  input  logic       cfifo_empty,
  input  logic [1:0] cent_typ,
  input  logic       fmt_done,
  output logic       cnt_clr,
  output logic       road_inc,
  output logic       drop_inc,
  output logic       cap,
  output logic       cfifo_rd,
  output logic       cmp_we,
  output logic       cmp_rd,
  output logic       mask_rd,
  output logic       zfifo_wr,
  output logic       hits_busy
);
  rhc_state_t state, state_d;
  logic       last_q;

  assign cnt_clr  = (state == S_IDLE) && evt_start;
  assign road_inc = (state == S_FIRST) && road_wr && !roads_full;
  assign cap      = (state == S_DECIDE);
  assign drop_inc = (state == S_DECIDE) && !cent_typ[1];

  always_comb begin
    state_d = state;
    unique case (state)
      S_IDLE:     if (evt_start) state_d = S_FIRST;
      S_FIRST: begin
        if (road_wr)        state_d = roads_full ? S_RELEASE : S_LOAD;
        else if (road_last) state_d = S_NEXT;
      end
      S_LOAD:     state_d = S_RELEASE;
      S_RELEASE:  if (!road_wr) state_d = last_q ? S_NEXT : S_FIRST;
      S_NEXT, S_DWAIT: begin
        if (!cfifo_empty)   state_d = S_READ;
        else if (evt_end)   state_d = S_IDLE;
        else                state_d = S_DWAIT;
      end
      S_READ:     state_d = S_DECIDE;
      S_DECIDE: begin
        if (cent_typ == TYP_Z)       state_d = S_ZWRITE;
        else if (cent_typ == TYP_AX) state_d = S_CMP;
        else                         state_d = S_NEXT;
      end
      S_ZWRITE:   state_d = S_NEXT;
      S_CMP:      state_d = S_MASK;
      S_MASK:     state_d = S_WAITDONE;
      S_WAITDONE: if (fmt_done) state_d = S_NEXT;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      last_q    <= 1'b0;
      cfifo_rd  <= 1'b0;
      cmp_we    <= 1'b0;
      cmp_rd    <= 1'b0;
      mask_rd   <= 1'b0;
      zfifo_wr  <= 1'b0;
      hits_busy <= 1'b0;
    end else begin
      state     <= state_d;
      if (state == S_IDLE)
        last_q <= 1'b0;
      else if (state == S_FIRST && road_wr && road_last)
        last_q <= 1'b1;
      cfifo_rd  <= (state_d == S_READ);
      cmp_we    <= (state_d == S_LOAD);
      cmp_rd    <= (state_d == S_CMP);
      mask_rd   <= (state_d == S_MASK);
      zfifo_wr  <= (state_d == S_ZWRITE);
      hits_busy <= (state_d != S_IDLE) && (hits_busy || state_d == S_READ);
    end
  end

  // R7: a centroid read always happens with busy raised
  a_r7_busy_on_read: assert property (@(posedge clk) disable iff (rst)
    cfifo_rd |-> hits_busy);

  // R9: the mask read follows the comparator read by one cycle
  a_r9_mask_after_cmp: assert property (@(posedge clk) disable iff (rst)
    mask_rd |-> $past(cmp_rd));

  // R6: no centroid read while roads are loading
  a_r6_no_read_loading: assert property (@(posedge clk) disable iff (rst)
    (state == S_FIRST || state == S_LOAD || state == S_RELEASE) |-> !cfifo_rd);

  // R10: no read while the formatter is still working
  a_r10_hold_for_done: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAITDONE) |-> !cfifo_rd);

  // R8, R9: at most one strobe at a time
  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cfifo_rd, cmp_we, cmp_rd, mask_rd, zfifo_wr}));
endmodule

// File: rtl/road_hit_ctrl.sv
module road_hit_ctrl #(
  parameter  int DW        = 16,
  parameter  int MAX_ROADS = 12,
  parameter  int DROPW     = 8,
  localparam int PW        = DW - 2,
  localparam int CW        = $clog2(MAX_ROADS + 1),
  localparam int SELW      = (MAX_ROADS > 1) ? $clog2(MAX_ROADS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_start,
  input  logic             evt_end,
  input  logic             road_wr,
  input  logic             road_last,
  output logic             cmp_we,
  output logic [SELW-1:0]  cmp_sel,
  output logic [CW-1:0]    road_cnt,
  input  logic             cfifo_empty,
  output logic             cfifo_rd,
  input  logic [DW-1:0]    cfifo_data,
  output logic [PW-1:0]    cent_word,
  output logic             cmp_rd,
  output logic             mask_rd,
  input  logic             fmt_done,
  output logic             zfifo_wr,
  output logic             hits_busy,
  output logic [DROPW-1:0] drop_cnt
);
  logic cnt_clr, road_inc, drop_inc, cap, roads_full, drop_full;

  rhc_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .evt_start   (evt_start),
    .evt_end     (evt_end),
    .road_wr     (road_wr),
    .road_last   (road_last),
    .roads_full  (roads_full),
    .cfifo_empty (cfifo_empty),
    .cent_typ    (cfifo_data[DW-1:DW-2]),
    .fmt_done    (fmt_done),
    .cnt_clr     (cnt_clr),
    .road_inc    (road_inc),
    .drop_inc    (drop_inc),
    .cap         (cap),
    .cfifo_rd    (cfifo_rd),
    .cmp_we      (cmp_we),
    .cmp_rd      (cmp_rd),
    .mask_rd     (mask_rd),
    .zfifo_wr    (zfifo_wr),
    .hits_busy   (hits_busy)
  );

  rhc_sat_counter #(.MAX(MAX_ROADS), .W(CW)) u_roads (
    .clk  (clk),
    .rst  (rst),
    .clr  (cnt_clr),
    .inc  (road_inc),
    .cnt  (road_cnt),
    .full (roads_full)
  );

  rhc_sat_counter #(.MAX((1 << DROPW) - 1), .W(DROPW)) u_drops (
    .clk  (clk),
    .rst  (rst),
    .clr  (cnt_clr),
    .inc  (drop_inc),
    .cnt  (drop_cnt),
    .full (drop_full)
  );

  rhc_cent_latch #(.DW(DW)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .cap     (cap),
    .din     (cfifo_data),
    .payload (cent_word)
  );

  always_ff @(posedge clk) begin
    if (rst)
      cmp_sel <= '0;
    else if (road_inc)
      cmp_sel <= road_cnt[SELW-1:0];
  end

  // R3: each comparator load uses an index below the resulting count
  a_r3_sel_in_range: assert property (@(posedge clk) disable iff (rst)
    cmp_we |-> (CW'(cmp_sel) < road_cnt));

  // R11: a drop never saturates silently in short runs
  a_r11_drop_room: assert property (@(posedge clk) disable iff (rst)
    drop_inc |-> !drop_full || $stable(drop_cnt));
endmodule

// File: tb/road_hit_ctrl_bench.sv
module road_hit_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int DW = 16;
  localparam int MAXR = 12;
  localparam int PW = DW - 2;
  localparam int FDLY = 3;

  logic clk = 0, rst = 1;
  logic evt_start = 0, evt_end = 0, road_wr = 0, road_last = 0;
  logic cmp_we, cmp_rd, mask_rd, zfifo_wr, hits_busy, cfifo_rd, cfifo_empty;
  logic [3:0] cmp_sel;
  logic [3:0] road_cnt;
  logic [DW-1:0] cfifo_data = '0;
  logic [PW-1:0] cent_word;
  logic [7:0] drop_cnt;
  logic fmt_auto = 1, fmt_man = 0, fmt_pulse = 0, fmt_done;
  int   fcnt = 0;

  int checks = 0, fails = 0;
  int n_rd = 0, n_we = 0, n_cmp = 0, n_mask = 0, n_z = 0;
  logic [PW-1:0] z_last = '0, cmp_last = '0;
  logic [3:0] sels [0:15];

  logic [DW-1:0] fmem [0:15];
  logic [3:0] rp = 0, wp = 0;

  always #(CLK_P/2) clk = ~clk;

  assign cfifo_empty = (rp == wp);
  assign fmt_done = fmt_pulse | fmt_man;

  road_hit_ctrl u_road_hit_ctrl (
    .clk(clk), .rst(rst), .evt_start(evt_start), .evt_end(evt_end),
    .road_wr(road_wr), .road_last(road_last), .cmp_we(cmp_we),
    .cmp_sel(cmp_sel), .road_cnt(road_cnt), .cfifo_empty(cfifo_empty),
    .cfifo_rd(cfifo_rd), .cfifo_data(cfifo_data), .cent_word(cent_word),
    .cmp_rd(cmp_rd), .mask_rd(mask_rd), .fmt_done(fmt_done),
    .zfifo_wr(zfifo_wr), .hits_busy(hits_busy), .drop_cnt(drop_cnt)
  );

  // centroid FIFO model: word appears the cycle after the read strobe
  always @(posedge clk) begin
    if (cfifo_rd) begin
      cfifo_data <= fmem[rp];
      rp <= rp + 1'b1;
    end
  end

  // formatter model: done pulse FDLY cycles after mask read
  always @(posedge clk) begin
    fmt_pulse <= 1'b0;
    if (mask_rd) fcnt <= FDLY;
    else if (fcnt > 0) begin
      fcnt <= fcnt - 1;
      if (fcnt == 1 && fmt_auto) fmt_pulse <= 1'b1;
    end
  end

  // strobe monitors
  always @(posedge clk) begin
    if (!rst) begin
      if (cfifo_rd) n_rd <= n_rd + 1;
      if (cmp_we) begin sels[n_we[3:0]] <= cmp_sel; n_we <= n_we + 1; end
      if (cmp_rd) begin n_cmp <= n_cmp + 1; cmp_last <= cent_word; end
      if (mask_rd) n_mask <= n_mask + 1;
      if (zfifo_wr) begin n_z <= n_z + 1; z_last <= cent_word; end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [DW-1:0] w);
    fmem[wp] = w;
    wp = wp + 1'b1;
  endtask

  task automatic start_event();
    evt_end = 0;
    evt_start = 1; cyc(1); evt_start = 0; cyc(1);
  endtask

  task automatic road(input logic last);
    road_wr = 1; road_last = last; cyc(2);
    road_wr = 0; road_last = 0; cyc(1);
  endtask

  task automatic close_event();
    evt_end = 1; cyc(4); evt_end = 0;
  endtask

  task automatic t_reset();
    chk("R1 hits_busy", hits_busy, 0);
    chk("R1 strobes", {cfifo_rd, cmp_we, cmp_rd, mask_rd, zfifo_wr}, 0);
    chk("R1 road_cnt", road_cnt, 0);
    chk("R1 drop_cnt", drop_cnt, 0);
  endtask

  task automatic t_load_and_route();
    int we0, rd0;
    we0 = n_we; rd0 = n_rd;
    start_event();
    push({2'b10, 14'h1234});
    push({2'b11, 14'h0ABC});
    road(0); road(0);
    chk("R6 no read during loading", n_rd - rd0, 0);
    road(1);
    chk("R3 three loads", n_we - we0, 3);
    chk("R3 sel0", sels[we0[3:0]], 0);
    chk("R3 sel2", sels[we0[3:0] + 4'd2], 2);
    chk("R5 count after last with write", road_cnt, 3);
    cyc(25);
    chk("R7 reads", n_rd - rd0, 2);
    chk("R7 busy while open", hits_busy, 1);
    chk("R8 z writes", n_z, 1);
    chk("R8 z payload", z_last, 14'h1234);
    chk("R9 cmp reads", n_cmp, 1);
    chk("R9 mask reads", n_mask, 1);
    chk("R9 cmp payload", cmp_last, 14'h0ABC);
    chk("R12 parked with FIFO empty", int'(cfifo_empty), 1);
    push({2'b01, 14'h0055});
    cyc(8);
    chk("R12 resumed read", n_rd - rd0, 3);
    chk("R11 drop count", drop_cnt, 1);
    chk("R11 no z write", n_z, 1);
    chk("R11 no cmp read", n_cmp, 1);
    close_event();
    chk("R12 busy falls at event end", hits_busy, 0);
  endtask

  task automatic t_saturate();
    int we0;
    we0 = n_we;
    start_event();
    chk("R2 road_cnt cleared", road_cnt, 0);
    chk("R2 drop_cnt cleared", drop_cnt, 0);
    for (int i = 0; i < MAXR + 2; i++) road(0);
    chk("R4 loads capped", n_we - we0, MAXR);
    chk("R4 count capped", road_cnt, MAXR);
    road_last = 1; cyc(1); road_last = 0;
    evt_end = 1; cyc(4);
    chk("R12 idle with no centroids", hits_busy, 0);
    evt_end = 0;
  endtask

  task automatic t_no_roads();
    int we0;
    we0 = n_we;
    start_event();
    road_last = 1; cyc(1); road_last = 0;
    cyc(2);
    chk("R5 no roads count", road_cnt, 0);
    chk("R5 no loads", n_we - we0, 0);
    close_event();
  endtask

  task automatic t_done_wait();
    int rd0, z0, m0;
    rd0 = n_rd; z0 = n_z; m0 = n_mask;
    fmt_auto = 0;
    start_event();
    road(1);
    push({2'b11, 14'h0111});
    push({2'b10, 14'h0222});
    cyc(15);
    chk("R10 mask issued", n_mask - m0, 1);
    chk("R10 held reads", n_rd - rd0, 1);
    chk("R10 z held back", n_z - z0, 0);
    fmt_man = 1; cyc(1); fmt_man = 0;
    cyc(8);
    chk("R10 resumed after done", n_rd - rd0, 2);
    chk("R8 z after done", z_last, 14'h0222);
    fmt_auto = 1;
    close_event();
  endtask

  initial begin
    cyc(3);
    rst = 0;
    cyc(1);
    t_reset();
    t_load_and_route();
    t_saturate();
    t_no_roads();
    t_done_wait();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule